// File: doc/BRIEF.md
# Timer Compare Match Unit

This block watches a free-running 16-bit timer that runs on the module clock and compares its count against a programmable 16-bit compare value. When the count first becomes equal to that value, the unit carries out the single action picked by a 4-bit mode code. It can invert, raise or lower an output latch. It can fire a special event that asks the timer to restart from zero and, optionally, starts an ADC conversion. It can also raise nothing but an interrupt flag. Every active mode sets the sticky interrupt flag in the same cycle as its action. Software clears the flag with a strobe.

Software programs the unit through two write strobes, one for the mode and one for the compare value. The timer itself sits outside the block, and so do its prescaler, its gating, the pin multiplexing and the ADC. The restart request is a plain load-to-zero command. It is not an overflow, so a timer that follows it has no reason to raise its own overflow flag. The latch reaches the pin only while the pin-drive enable is high, and that enable is asserted only in the three latch modes.

Top module: `cmp_match_unit`

## Requirements
- R1: While reset is high and after it is released, cmp_out, cmp_oe, irq_flag, tmr_clear and adc_start are all 0.
- R2: A match happens in the first cycle in which tmr_count equals the stored compare value. The results appear at the clock edge that samples that equality. A count held at the compare value does not match again until it has left the value and come back.
- R3: In mode 4'b0010 a match inverts cmp_out.
- R4: In mode 4'b1000 a match drives cmp_out to 1. In mode 4'b1001 a match drives cmp_out to 0.
- R5: In modes 4'b0010, 4'b1000, 4'b1001, 4'b1010 and 4'b1011 a match sets irq_flag. In every other mode code a match sets nothing and changes no output.
- R6: irq_flag stays at 1 until a cycle with irq_clr high clears it. When irq_clr and a match fall in the same cycle, the flag ends at 1.
- R7: In mode 4'b1011 a match gives a one-cycle pulse on tmr_clear and leaves cmp_out unchanged.
- R8: With the ADC trigger option built in (HAS_ADC_TRIG=1), a match in mode 4'b1011 while adc_en is high also gives a one-cycle pulse on adc_start. In every other case adc_start stays at 0.
- R9: In mode 4'b1010 a match sets only irq_flag. cmp_oe stays 0 and cmp_out keeps its value.
- R10: cmp_oe is 1 exactly while the stored mode is 4'b0010, 4'b1000 or 4'b1001. The stored mode takes effect at the edge that writes it.
- R11: Writing mode 4'b0000 forces cmp_out to 0 at that same edge. Writing any other code leaves cmp_out as it was.
- R12: A compare-value write that makes the stored value equal to the count already present produces a match one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; the timer counts on this clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode code |
| mode_wdata | input | 4 | Mode code to store |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 16 | Compare value to store |
| tmr_count | input | 16 | Current timer count |
| irq_clr | input | 1 | Software clear strobe for irq_flag |
| adc_en | input | 1 | Allows the special event to start an ADC conversion |
| cmp_out | output | 1 | Compare output latch |
| cmp_oe | output | 1 | Pin-drive enable for cmp_out |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| tmr_clear | output | 1 | One-cycle request to load the timer with zero |
| adc_start | output | 1 | One-cycle ADC start-conversion request |

## Verification
The hardest case to reach is a latch that already holds a chosen value when a second mode is applied to it. From the ports alone, the latch can only be loaded through an earlier match. For each of the 16 mode codes, both adc_en levels and both latch values, the bench therefore preloads the latch with a set or clear match, clears the flag, switches to the mode under test and sends one more match. It then holds the count at the match value for an extra cycle so that a retrigger would show. It also lines up a clear strobe with a match, and it writes a compare value equal to a count that is being held still.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 4'b0000,
    MODE_TOGGLE  = 4'b0010,
    MODE_SET     = 4'b1000,
    MODE_CLR     = 4'b1001,
    MODE_SWI     = 4'b1010,
    MODE_SPECIAL = 4'b1011
  } cmp_mode_e;

  typedef struct packed {
    logic toggle;
    logic set;
    logic clr;
    logic irq;
    logic special;
    logic drive;
  } cmp_act_t;

  function automatic cmp_act_t decode_mode(input logic [MODE_W-1:0] m);
    cmp_act_t a;
    a = '0;
    case (m)
      MODE_TOGGLE:  begin a.toggle = 1'b1; a.irq = 1'b1; a.drive = 1'b1; end
      MODE_SET:     begin a.set = 1'b1;    a.irq = 1'b1; a.drive = 1'b1; end
      MODE_CLR:     begin a.clr = 1'b1;    a.irq = 1'b1; a.drive = 1'b1; end
      MODE_SWI:     begin a.irq = 1'b1; end
      MODE_SPECIAL: begin a.irq = 1'b1; a.special = 1'b1; end
      default:      a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/cmp_match_detect.sv
module cmp_match_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [CNT_W-1:0] tmr_count,
  output logic             hit
);
  logic [CNT_W-1:0] cmp_q;
  logic             eq;
  logic             eq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wdata;
      eq_q <= eq;
    end
  end

  // equality against the stored value; only its rising edge counts
  assign eq  = (tmr_count == cmp_q);
  assign hit = eq & ~eq_q;
endmodule

// File: rtl/cmp_mode_reg.sv
module cmp_mode_reg
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  output cmp_act_t          act,
  output logic              zero_wr
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_OFF;
    else if (mode_we) mode_q <= mode_wdata;
  end

  assign act     = decode_mode(mode_q);
  assign zero_wr = mode_we && (mode_wdata == MODE_OFF);
endmodule

// File: rtl/cmp_out_latch.sv
module cmp_out_latch (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic do_toggle,
  input  logic do_set,
  input  logic do_clr,
  input  logic drive,
  input  logic zero_wr,
  output logic cmp_out,
  output logic cmp_oe
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst || zero_wr)          out_q <= 1'b0;
    else if (hit && do_set)      out_q <= 1'b1;
    else if (hit && do_clr)      out_q <= 1'b0;
    else if (hit && do_toggle)   out_q <= ~out_q;
  end

  assign cmp_out = out_q;
  assign cmp_oe  = drive;
endmodule

// File: rtl/cmp_event_gen.sv
module cmp_event_gen #(
  parameter bit HAS_ADC_TRIG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic irq_en,
  input  logic special_en,
  input  logic irq_clr,
  input  logic adc_en,
  output logic irq_flag,
  output logic tmr_clear,
  output logic adc_start
);
  logic flag_q;
  logic clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      if (hit && irq_en) flag_q <= 1'b1;
      else if (irq_clr)  flag_q <= 1'b0;
      clr_q <= hit && special_en;
    end
  end

  generate
    if (HAS_ADC_TRIG) begin : g_adc
      logic adc_q;
      always_ff @(posedge clk) begin
        if (rst) adc_q <= 1'b0;
        else     adc_q <= hit && special_en && adc_en;
      end
      assign adc_start = adc_q;
    end else begin : g_no_adc
      logic unused_adc;
      assign unused_adc = adc_en;
      assign adc_start  = 1'b0;
    end
  endgenerate

  assign irq_flag  = flag_q;
  assign tmr_clear = clr_q;
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter bit HAS_ADC_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cmp_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic [CNT_W-1:0]  tmr_count,
  input  logic              irq_clr,
  input  logic              adc_en,
  output logic              cmp_out,
  output logic              cmp_oe,
  output logic              irq_flag,
  output logic              tmr_clear,
  output logic              adc_start
);
  logic     hit;
  logic     zero_wr;
  cmp_act_t act;

  cmp_match_detect #(.CNT_W(CNT_W)) u_detect (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .tmr_count(tmr_count), .hit(hit)
  );

  cmp_mode_reg u_mode (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .act(act), .zero_wr(zero_wr)
  );

  cmp_out_latch u_latch (
    .clk(clk), .rst(rst), .hit(hit),
    .do_toggle(act.toggle), .do_set(act.set), .do_clr(act.clr),
    .drive(act.drive), .zero_wr(zero_wr),
    .cmp_out(cmp_out), .cmp_oe(cmp_oe)
  );

  cmp_event_gen #(.HAS_ADC_TRIG(HAS_ADC_TRIG)) u_event (
    .clk(clk), .rst(rst), .hit(hit),
    .irq_en(act.irq), .special_en(act.special),
    .irq_clr(irq_clr), .adc_en(adc_en),
    .irq_flag(irq_flag), .tmr_clear(tmr_clear), .adc_start(adc_start)
  );
endmodule

// File: rtl/cmp_match_chk.sv
module cmp_match_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_we,
  input logic [3:0] mode_wdata,
  input logic       irq_clr,
  input logic       adc_en,
  input logic       cmp_out,
  input logic       cmp_oe,
  input logic       irq_flag,
  input logic       tmr_clear,
  input logic       adc_start
);
  // R11
  zero_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_we && mode_wdata == 4'b0000) |=> (!cmp_out && !cmp_oe));

  // R7
  special_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_clear |-> irq_flag);

  // R8
  adc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> (tmr_clear && $past(adc_en)));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_flag) |-> $past(irq_clr));

  // R3
  out_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_out) |-> irq_flag);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_clear |=> !tmr_clear);
endmodule

bind cmp_match_unit cmp_match_chk u_chk (
  .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
  .irq_clr(irq_clr), .adc_en(adc_en), .cmp_out(cmp_out), .cmp_oe(cmp_oe),
  .irq_flag(irq_flag), .tmr_clear(tmr_clear), .adc_start(adc_start)
);

// File: tb/sim_cmp_match_unit.sv
module sim_cmp_match_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [3:0]  mode_wdata = 4'b0;
  logic        cmp_we = 1'b0;
  logic [15:0] cmp_wdata = 16'h0;
  logic [15:0] tmr_count = 16'h0;
  logic        irq_clr = 1'b0;
  logic        adc_en = 1'b0;
  logic        cmp_out, cmp_oe, irq_flag, tmr_clear, adc_start;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cmp_match_unit u0 (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .tmr_count(tmr_count),
    .irq_clr(irq_clr), .adc_en(adc_en), .cmp_out(cmp_out), .cmp_oe(cmp_oe),
    .irq_flag(irq_flag), .tmr_clear(tmr_clear), .adc_start(adc_start)
  );

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [3:0] m);
    mode_we = 1'b1; mode_wdata = m;
    cyc;
    mode_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    cmp_we = 1'b1; cmp_wdata = v;
    cyc;
    cmp_we = 1'b0;
  endtask

  localparam logic [15:0] MATCH = 16'h0123;
  localparam logic [15:0] AWAY  = 16'h0100;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc; cyc;
    // R1 during reset
    chk("R1 out", cmp_out, 1'b0);
    chk("R1 flag", irq_flag, 1'b0);
    rst = 1'b0;
    cyc;
    chk("R1 oe", cmp_oe, 1'b0);
    chk("R1 clear", tmr_clear, 1'b0);
    chk("R1 adc", adc_start, 1'b0);

    tmr_count = AWAY;
    wr_cmp(MATCH);
    cyc;

    for (int m = 0; m < 16; m++) begin
      for (int a = 0; a < 2; a++) begin
        for (int pre = 0; pre < 2; pre++) begin
          logic pv, act_m, exp_out;
          // preload latch through a set or clear match
          tmr_count = AWAY;
          wr_mode(pre != 0 ? 4'b1000 : 4'b1001);
          tmr_count = MATCH; cyc;
          chk("R4 preload", cmp_out, pre != 0);
          tmr_count = AWAY; irq_clr = 1'b1; cyc; irq_clr = 1'b0;
          chk("R6 cleared", irq_flag, 1'b0);

          wr_mode(4'(m));
          pv = (m == 0) ? 1'b0 : (pre != 0);
          chk("R11 latch after mode write", cmp_out, pv);
          chk("R10 oe", cmp_oe, (m == 2 || m == 8 || m == 9));

          act_m = (m == 2 || m == 8 || m == 9 || m == 10 || m == 11);
          exp_out = (m == 2) ? ~pv : (m == 8) ? 1'b1 : (m == 9) ? 1'b0 : pv;
          adc_en = (a != 0);
          tmr_count = MATCH; cyc;
          // R3 R4 R9 latch action, R5 flag, R7 clear, R8 adc
          chk("R3/R4/R9 out", cmp_out, exp_out);
          chk("R5 flag", irq_flag, act_m);
          chk("R7 clear", tmr_clear, m == 11);
          chk("R8 adc", adc_start, (m == 11) && (a != 0));

          cyc; // count held at match value
          chk("R2 no retrigger out", cmp_out, exp_out);
          chk("R2 clear pulse ends", tmr_clear, 1'b0);
          chk("R8 adc pulse ends", adc_start, 1'b0);
          chk("R6 flag sticky", irq_flag, act_m);

          tmr_count = AWAY; irq_clr = 1'b1; adc_en = 1'b0; cyc; irq_clr = 1'b0;
        end
      end
    end

    // R6: clear strobe coincides with a match; set wins
    wr_mode(4'b1010);
    tmr_count = MATCH; cyc;
    chk("R6 flag set", irq_flag, 1'b1);
    tmr_count = AWAY; cyc;
    tmr_count = MATCH; irq_clr = 1'b1; cyc; irq_clr = 1'b0;
    chk("R6 set wins over clear", irq_flag, 1'b1);
    tmr_count = AWAY; irq_clr = 1'b1; cyc; irq_clr = 1'b0;
    chk("R6 clear alone", irq_flag, 1'b0);

    // R12: compare write equal to a count held still
    tmr_count = 16'h0050; cyc;
    wr_cmp(16'h0050);
    chk("R12 not yet at write edge", irq_flag, 1'b0);
    cyc;
    chk("R12 match after write", irq_flag, 1'b1);
    cyc;
    chk("R2 held count", irq_flag, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule